// File: doc/BRIEF.md
# Segmented Multi-Queue Buffer Controller

This block manages the read and write pointers of many circular output queues that all live in one shared on-chip message buffer. Software gives each queue a configuration word. The word names a region: a 1024-entry window selected by a base field. It also names a first and a last 32-entry segment inside that region. The queue's storage is the contiguous run of segments between those two. Because the base bits are shared by both segment bounds, a queue can never straddle a region boundary.

Agents issue enqueue or dequeue requests tagged with a queue id. The controller checks the queue's state, accepts or rejects the access, and returns the physical entry address one cycle later. It splits that address into a bank index and an in-bank row, so that consecutive entries of a queue fall in consecutive banks of the payload memory. Per-queue full and empty flags are always visible. The payload memory itself sits outside this block.

Top module: `cmq_buffer_ctrl`

## Requirements
- R1: The config word holds the start segment in bits [SEGS_LOG2-1:0], the end segment in the next SEGS_LOG2 bits, the region base in the BASE_W bits above those, and an enable flag in bit 63. Writing a queue's config empties the queue and places its head and tail on entry 0 of the start segment.
- R2: An accepted enqueue returns the address {base, tail}, where tail is a region offset, and then advances the tail by one.
- R3: An accepted dequeue returns the address {base, head} and then advances the head by one, so entries are read back in the order they were written.
- R4: When head or tail leaves the last entry of the end segment, it reloads to entry 0 of the start segment.
- R5: A queue is full when its occupancy equals (end-start+1) times the segment size. An enqueue to a full queue is rejected with an error pulse, and its pointers do not change.
- R6: A dequeue from an empty queue is rejected with an error pulse, and its pointers do not change.
- R7: A queue whose enable flag is 0 rejects every access. It reads as empty and not full.
- R8: A config whose end segment is below its start segment makes the queue behave as disabled.
- R9: The bank index is the low BANK_LOG2 bits of the returned address, and the row is the remaining upper bits. Successive enqueues to one queue therefore step through banks cyclically, including across a wrap.
- R10: Each request cycle produces exactly one of op_ack or op_err in the following cycle. Neither is raised without a request.
- R11: A config write and an access to the same queue in the same cycle: the config write takes effect and the access is rejected.
- R12: After reset every queue is disabled and empty, and op_ack and op_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_qid | input | QID_W | Queue targeted by the config write |
| cfg_data | input | 64 | Config word |
| op_valid | input | 1 | Access request |
| op_is_enq | input | 1 | 1 = enqueue, 0 = dequeue |
| op_qid | input | QID_W | Queue targeted by the access |
| op_ack | output | 1 | Access accepted (one cycle after the request) |
| op_err | output | 1 | Access rejected (one cycle after the request) |
| op_addr | output | ADDR_W | Physical entry address of the last accepted access |
| op_bank | output | BANK_LOG2 | Bank index of op_addr |
| op_row | output | ADDR_W-BANK_LOG2 | Row within the bank of op_addr |
| q_full | output | NUM_Q | Per-queue full flag |
| q_empty | output | NUM_Q | Per-queue empty flag |

## Verification
The bench builds the block with 4 queues, 4-entry segments, 8 segments per region, 4 regions and 4 banks. That gives a 128-entry buffer in which one queue can hold from 4 to 32 entries. At that scale every start/end segment pair (all 64, including the invalid ones) can be configured and then filled and drained past full and past empty. Every pointer position, wrap point, full boundary and bank step is therefore reached, and the expected addresses come from plain arithmetic on base, start and end.

// File: rtl/cmq_pkg.sv
package cmq_pkg;

    localparam int CFG_W      = 64;
    localparam int CFG_EN_BIT = 63;

    typedef enum logic {
        ACC_DEQ = 1'b0,
        ACC_ENQ = 1'b1
    } access_e;

    // Number of entries spanned by segments start..end.
    function automatic int unsigned span_cap(int unsigned first_seg,
                                             int unsigned last_seg,
                                             int unsigned seg_log2);
        return (last_seg - first_seg + 1) << seg_log2;
    endfunction

    // Region offset following ptr, wrapping from the end segment's top entry
    // back to the start segment's first entry.
    function automatic int unsigned ptr_advance(int unsigned ptr,
                                                int unsigned first_seg,
                                                int unsigned last_seg,
                                                int unsigned seg_log2);
        int unsigned top;
        top = ((last_seg + 1) << seg_log2) - 1;
        return (ptr == top) ? (first_seg << seg_log2) : ptr + 1;
    endfunction

endpackage

// File: rtl/cmq_queue_slot.sv
module cmq_queue_slot
    import cmq_pkg::*;
#(
    parameter int SEG_LOG2  = 5,
    parameter int SEGS_LOG2 = 5,
    parameter int BASE_W    = 5,
    localparam int OFF_W    = SEGS_LOG2 + SEG_LOG2,
    localparam int OCC_W    = OFF_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic                 cfg_en,
    input  logic [SEGS_LOG2-1:0] cfg_start,
    input  logic [SEGS_LOG2-1:0] cfg_end,
    input  logic [BASE_W-1:0]    cfg_base,
    input  logic                 push,
    input  logic                 pop,
    output logic                 valid,
    output logic [BASE_W-1:0]    base,
    output logic [OFF_W-1:0]     head,
    output logic [OFF_W-1:0]     tail,
    output logic                 full,
    output logic                 empty
);

    logic                 en_q;
    logic [SEGS_LOG2-1:0] start_q, end_q;
    logic [BASE_W-1:0]    base_q;
    logic [OFF_W-1:0]     head_q, tail_q;
    logic [OCC_W-1:0]     occ_q;
    logic [OCC_W-1:0]     cap;
    logic [OFF_W-1:0]     span_first, span_last;

    assign valid      = en_q && (end_q >= start_q);
    assign cap        = valid ? OCC_W'(span_cap(32'(start_q), 32'(end_q), SEG_LOG2)) : '0;
    assign span_first = {start_q, {SEG_LOG2{1'b0}}};
    assign span_last  = {end_q, {SEG_LOG2{1'b1}}};

    assign full  = valid && (occ_q == cap);
    assign empty = (occ_q == '0);
    assign base  = base_q;
    assign head  = head_q;
    assign tail  = tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            start_q <= '0;
            end_q   <= '0;
            base_q  <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            occ_q   <= '0;
        end else if (cfg_we) begin
            en_q    <= cfg_en;
            start_q <= cfg_start;
            end_q   <= cfg_end;
            base_q  <= cfg_base;
            head_q  <= {cfg_start, {SEG_LOG2{1'b0}}};
            tail_q  <= {cfg_start, {SEG_LOG2{1'b0}}};
            occ_q   <= '0;
        end else begin
            case ({push, pop})
                2'b10: begin
                    tail_q <= OFF_W'(ptr_advance(32'(tail_q), 32'(start_q), 32'(end_q), SEG_LOG2));
                    occ_q  <= occ_q + 1'b1;
                end
                2'b01: begin
                    head_q <= OFF_W'(ptr_advance(32'(head_q), 32'(start_q), 32'(end_q), SEG_LOG2));
                    occ_q  <= occ_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    p_occ_bound_r5: assert property (@(posedge clk) disable iff (rst)
        valid |-> (occ_q <= cap));

    p_head_span_r4: assert property (@(posedge clk) disable iff (rst)
        valid |-> (head_q >= span_first && head_q <= span_last));

    p_tail_span_r4: assert property (@(posedge clk) disable iff (rst)
        valid |-> (tail_q >= span_first && tail_q <= span_last));

    p_cfg_clears_r1: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (empty && head_q == tail_q));

    p_push_room_r5: assert property (@(posedge clk) disable iff (rst)
        push |-> (valid && !full));

    p_pop_data_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> (valid && !empty));

endmodule

// File: rtl/cmq_bank_map.sv
module cmq_bank_map #(
    parameter int ADDR_W    = 15,
    parameter int BANK_LOG2 = 3,
    localparam int ROW_W    = ADDR_W - BANK_LOG2
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [BANK_LOG2-1:0] bank,
    output logic [ROW_W-1:0]     row
);

    // Low address bits pick the bank so neighbouring entries land in
    // neighbouring banks; every span is segment aligned, so a wrap also steps
    // to the next bank.
    assign bank = addr[BANK_LOG2-1:0];
    assign row  = addr[ADDR_W-1:BANK_LOG2];

endmodule

// File: rtl/cmq_buffer_ctrl.sv
module cmq_buffer_ctrl
    import cmq_pkg::*;
#(
    parameter int NUM_Q     = 32,
    parameter int SEG_LOG2  = 5,
    parameter int SEGS_LOG2 = 5,
    parameter int BASE_W    = 5,
    parameter int BANK_LOG2 = 3,
    localparam int QID_W    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int OFF_W    = SEGS_LOG2 + SEG_LOG2,
    localparam int ADDR_W   = BASE_W + OFF_W,
    localparam int ROW_W    = ADDR_W - BANK_LOG2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [QID_W-1:0]     cfg_qid,
    input  logic [CFG_W-1:0]     cfg_data,
    input  logic                 op_valid,
    input  logic                 op_is_enq,
    input  logic [QID_W-1:0]     op_qid,
    output logic                 op_ack,
    output logic                 op_err,
    output logic [ADDR_W-1:0]    op_addr,
    output logic [BANK_LOG2-1:0] op_bank,
    output logic [ROW_W-1:0]     op_row,
    output logic [NUM_Q-1:0]     q_full,
    output logic [NUM_Q-1:0]     q_empty
);

    localparam int END_LSB  = SEGS_LOG2;
    localparam int BASE_LSB = 2 * SEGS_LOG2;

    // Config word fields
    logic [SEGS_LOG2-1:0] f_start, f_end;
    logic [BASE_W-1:0]    f_base;
    logic                 f_en;
    logic                 unused_cfg_bits;

    assign f_start = cfg_data[SEGS_LOG2-1:0];
    assign f_end   = cfg_data[END_LSB +: SEGS_LOG2];
    assign f_base  = cfg_data[BASE_LSB +: BASE_W];
    assign f_en    = cfg_data[CFG_EN_BIT];
    assign unused_cfg_bits = ^cfg_data[CFG_EN_BIT-1:BASE_LSB+BASE_W];

    logic [NUM_Q-1:0]  slot_we, push_v, pop_v, valid_v;
    logic [BASE_W-1:0] base_a [NUM_Q];
    logic [OFF_W-1:0]  head_a [NUM_Q];
    logic [OFF_W-1:0]  tail_a [NUM_Q];

    access_e           kind;
    logic              sel_ok, collide, room, accept;
    logic [QID_W-1:0]  sel_idx;
    logic [ADDR_W-1:0] addr_next;

    assign kind    = access_e'(op_is_enq);
    assign sel_ok  = int'(op_qid) < NUM_Q;
    assign sel_idx = sel_ok ? op_qid : '0;
    assign collide = cfg_we && (cfg_qid == op_qid);
    assign room    = (kind == ACC_ENQ) ? !q_full[sel_idx] : !q_empty[sel_idx];
    assign accept  = op_valid && sel_ok && valid_v[sel_idx] && !collide && room;

    assign addr_next = {base_a[sel_idx],
                        (kind == ACC_ENQ) ? tail_a[sel_idx] : head_a[sel_idx]};

    for (genvar g = 0; g < NUM_Q; g++) begin : g_slot
        assign slot_we[g] = cfg_we && (cfg_qid == QID_W'(g));
        assign push_v[g]  = accept && (kind == ACC_ENQ) && (op_qid == QID_W'(g));
        assign pop_v[g]   = accept && (kind == ACC_DEQ) && (op_qid == QID_W'(g));

        cmq_queue_slot #(
            .SEG_LOG2 (SEG_LOG2),
            .SEGS_LOG2(SEGS_LOG2),
            .BASE_W   (BASE_W)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .cfg_we   (slot_we[g]),
            .cfg_en   (f_en),
            .cfg_start(f_start),
            .cfg_end  (f_end),
            .cfg_base (f_base),
            .push     (push_v[g]),
            .pop      (pop_v[g]),
            .valid    (valid_v[g]),
            .base     (base_a[g]),
            .head     (head_a[g]),
            .tail     (tail_a[g]),
            .full     (q_full[g]),
            .empty    (q_empty[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_ack  <= 1'b0;
            op_err  <= 1'b0;
            op_addr <= '0;
        end else begin
            op_ack <= accept;
            op_err <= op_valid && !accept;
            if (accept) op_addr <= addr_next;
        end
    end

    cmq_bank_map #(
        .ADDR_W   (ADDR_W),
        .BANK_LOG2(BANK_LOG2)
    ) u_bank (
        .addr(op_addr),
        .bank(op_bank),
        .row (op_row)
    );

    p_resp_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(op_ack && op_err));

    p_resp_cause_r10: assert property (@(posedge clk) disable iff (rst)
        (op_ack || op_err) |-> $past(op_valid));

    p_sel_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({push_v, pop_v}));

    p_collide_r11: assert property (@(posedge clk) disable iff (rst)
        (op_valid && collide) |=> op_err);

    p_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !valid_v[sel_idx]) |=> op_err);

endmodule

// File: tb/sim_cmq_buffer_ctrl.sv
`timescale 1ns/1ps
module sim_cmq_buffer_ctrl;

    localparam int NQ = 4;
    localparam int SL = 2;   // entries per segment = 4
    localparam int SG = 3;   // segments per region = 8
    localparam int BW = 2;   // regions = 4
    localparam int BL = 2;   // banks = 4
    localparam int SEGN   = 1 << SL;
    localparam int REGION = 1 << (SG + SL);
    localparam int NBANK  = 1 << BL;
    localparam int AW = BW + SG + SL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_qid = '0;
    logic [63:0] cfg_data = '0;
    logic op_valid = 1'b0;
    logic op_is_enq = 1'b0;
    logic [1:0] op_qid = '0;
    logic op_ack, op_err;
    logic [AW-1:0] op_addr;
    logic [BL-1:0] op_bank;
    logic [AW-BL-1:0] op_row;
    logic [NQ-1:0] q_full, q_empty;

    always #2.5 clk = ~clk;

    cmq_buffer_ctrl #(
        .NUM_Q(NQ), .SEG_LOG2(SL), .SEGS_LOG2(SG), .BASE_W(BW), .BANK_LOG2(BL)
    ) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_data(cfg_data),
        .op_valid(op_valid), .op_is_enq(op_is_enq), .op_qid(op_qid),
        .op_ack(op_ack), .op_err(op_err), .op_addr(op_addr), .op_bank(op_bank),
        .op_row(op_row), .q_full(q_full), .q_empty(q_empty)
    );

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    int m_en[NQ], m_s[NQ], m_e[NQ], m_b[NQ], m_head[NQ], m_tail[NQ], m_occ[NQ], m_pbank[NQ];

    task automatic chk(string req, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mvalid(int q);
        return (m_en[q] != 0 && m_e[q] >= m_s[q]) ? 1 : 0;
    endfunction

    function automatic int mcap(int q);
        return (m_e[q] - m_s[q] + 1) * SEGN;
    endfunction

    function automatic int madv(int q, int p);
        return (p == (m_e[q] + 1) * SEGN - 1) ? m_s[q] * SEGN : p + 1;
    endfunction

    task automatic model_cfg(int q, int en, int s, int e, int b);
        m_en[q] = en; m_s[q] = s; m_e[q] = e; m_b[q] = b;
        m_head[q] = s * SEGN; m_tail[q] = s * SEGN; m_occ[q] = 0; m_pbank[q] = -1;
    endtask

    function automatic logic [63:0] word(int en, int s, int e, int b);
        logic [63:0] d;
        d = '0;
        d[SG-1:0]      = SG'(s);
        d[2*SG-1:SG]   = SG'(e);
        d[2*SG+BW-1:2*SG] = BW'(b);
        d[63]          = en[0];
        return d;
    endfunction

    task automatic status_chk(int q);
        chk("R5 full flag", int'(q_full[q]), (mvalid(q) != 0 && m_occ[q] == mcap(q)) ? 1 : 0);
        chk("R6 empty flag", int'(q_empty[q]), (m_occ[q] == 0) ? 1 : 0);
    endtask

    task automatic do_cfg(int q, int en, int s, int e, int b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_qid = 2'(q); cfg_data = word(en, s, e, b);
        @(negedge clk);
        cfg_we = 1'b0;
        model_cfg(q, en, s, e, b);
        chk("R1 empty after config", int'(q_empty[q]), 1);
        chk("R1 not full after config", int'(q_full[q]), 0);
    endtask

    task automatic do_op(int enq, int q);
        int ok, addr;
        ok = (mvalid(q) != 0) && ((enq != 0) ? (m_occ[q] < mcap(q)) : (m_occ[q] > 0));
        addr = m_b[q] * REGION + ((enq != 0) ? m_tail[q] : m_head[q]);
        @(negedge clk);
        op_valid = 1'b1; op_is_enq = enq[0]; op_qid = 2'(q);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R10 ack", int'(op_ack), ok);
        if (ok == 0) begin
            if (mvalid(q) == 0) chk("R7 R8 rejected access", int'(op_err), 1);
            else if (enq != 0) chk("R5 enqueue to full rejected", int'(op_err), 1);
            else chk("R6 dequeue from empty rejected", int'(op_err), 1);
        end else begin
            chk("R10 no error", int'(op_err), 0);
            if (enq != 0) chk("R2 enqueue address", int'(op_addr), addr);
            else chk("R3 dequeue address", int'(op_addr), addr);
            chk("R9 bank", int'(op_bank), addr % NBANK);
            chk("R9 row", int'(op_row), addr / NBANK);
            if (enq != 0) begin
                if (m_pbank[q] >= 0) chk("R9 bank step", int'(op_bank), (m_pbank[q] + 1) % NBANK);
                m_pbank[q] = addr % NBANK;
                m_tail[q] = madv(q, m_tail[q]);   // R4 wrap in model
                m_occ[q]++;
            end else begin
                m_head[q] = madv(q, m_head[q]);
                m_occ[q]--;
            end
        end
        status_chk(q);
    endtask

    task automatic fill_drain(int q, int rounds);
        for (int r = 0; r < rounds; r++) begin
            for (int i = 0; i <= mcap(q); i++) do_op(1, q);
            for (int i = 0; i <= mcap(q); i++) do_op(0, q);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nvec++; nbad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        for (int q = 0; q < NQ; q++) model_cfg(q, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 ack low", int'(op_ack), 0);
        chk("R12 err low", int'(op_err), 0);
        chk("R12 all empty", int'(q_empty), 15);
        chk("R12 none full", int'(q_full), 0);

        // R7 unconfigured queue rejects
        do_op(1, 0);
        do_op(0, 0);

        do_cfg(0, 1, 0, 0, 0);
        do_cfg(1, 1, 2, 5, 1);
        do_cfg(2, 1, 0, 7, 2);
        do_cfg(3, 1, 5, 3, 3);   // R8 invalid span

        for (int q = 0; q < 3; q++) fill_drain(q, 2);   // R2 R3 R4 R5 R6
        do_op(1, 3);
        do_op(0, 3);
        chk("R8 invalid queue empty", int'(q_empty[3]), 1);

        // Mixed patterns with moving wrap point
        for (int i = 0; i < 60; i++) do_op((i % 3 != 2) ? 1 : 0, 1);
        for (int i = 0; i < 48; i++) do_op(i % 2, i % 3);

        // R1 reconfigure mid-fill
        for (int i = 0; i < 5; i++) do_op(1, 2);
        do_cfg(2, 1, 1, 2, 0);
        do_op(1, 2);
        do_op(0, 2);

        // R7 explicitly disabled queue
        do_cfg(1, 0, 0, 1, 2);
        do_op(1, 1);
        do_op(0, 1);
        chk("R7 disabled not full", int'(q_full[1]), 0);

        // R11 config and access collide on one queue
        do_op(1, 0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_qid = 2'd0; cfg_data = word(1, 3, 4, 1);
        op_valid = 1'b1; op_is_enq = 1'b1; op_qid = 2'd0;
        @(negedge clk);
        cfg_we = 1'b0; op_valid = 1'b0;
        model_cfg(0, 1, 3, 4, 1);
        chk("R11 colliding access rejected", int'(op_err), 1);
        chk("R11 colliding access not acked", int'(op_ack), 0);
        chk("R11 config applied, queue empty", int'(q_empty[0]), 1);
        do_op(1, 0);   // lands at start of new span

        // Exhaustive span sweep on queue 3
        for (int s = 0; s < (1 << SG); s++)
            for (int e = 0; e < (1 << SG); e++) begin
                do_cfg(3, 1, s, e, (s + e) % (1 << BW));
                if (e >= s) fill_drain(3, 1);
                else begin
                    do_op(1, 3);
                    do_op(0, 3);
                end
            end

        done = 1;
        summary();
        $finish;
    end

endmodule